// File: doc/BRIEF.md
# Flash Control Register Pair with Write-Sequence Unlock

This block holds the two byte-wide control registers that software uses to steer an on-chip flash controller. A CPU reaches them over a simple byte bus. A write is a one-cycle strobe with an address and a data byte. A read is combinational from the presented address. The control register holds the read-only ready/busy status, the rewrite-mode enable, the lock-disable bit, a controller-reset bit and the boot/user area select. The power register holds the flash power-off bit.

Three bits are protected against stray writes. These are rewrite mode, lock disable and power off. A protected bit only becomes 1 when the write of 1 is the next write to its register after a write of 0 to that bit. A write of 0 always clears the bit at once. Lock disable and controller reset only work while rewrite mode is on. Both are cleared as soon as rewrite mode goes off. Flash power is cut whenever the power-off bit is set or the CPU signals stop/wait. Power comes back on its own when the sleep indication drops.

The bus is a plain register port with no handshake. Every write strobe is accepted in the cycle it is presented, so there is no back-pressure.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the control register reads with bit0 equal to the ready input and all other bits 0. The power register reads 0. All control outputs are 0, and flash access is allowed when not sleeping.
- R2: Control register bit0 always reads the `flash_ready_i` input (1 = ready, 0 = busy).
- R3: Rewrite mode (control bit1) becomes 1 only when a write with bit1=1 is the next control-register write after one with bit1=0. A lone write of 1 leaves it 0. A write with bit1=0 clears it.
- R4: Lock disable (control bit2) follows the same 0-then-1 rule, and it can only be set while rewrite mode is already 1. It is cleared whenever rewrite mode is 0, and by any write that clears rewrite mode. `lock_off_o` is this bit.
- R5: Controller reset (control bit3) takes the written value only while rewrite mode is 1. It is 0 otherwise. `ctl_reset_o` is this bit.
- R6: Area select (control bit5) is stored as written. `user_area_o` equals that bit when `boot_mode_i` is 1, and is 1 when `boot_mode_i` is 0.
- R7: Power off (power register bit3) follows the 0-then-1 rule for writes to the power register. A write with bit3=0 clears it.
- R8: `flash_power_cut_o` is (power-off bit OR `cpu_sleep_i`), and `flash_access_ok_o` is its inverse.
- R9: Control bits 4, 6 and 7 and power bits other than bit3 read 0. Other addresses read 0, and writes to them change nothing.
- R10: The armed state of a protected bit is kept per register. A write to the other register between the 0 and the 1 does not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| flash_ready_i | input | 1 | Flash ready (1) / busy (0) status |
| boot_mode_i | input | 1 | Device started in boot mode |
| cpu_sleep_i | input | 1 | CPU is in stop or wait |
| rewrite_mode_o | output | 1 | Software rewrite commands enabled |
| lock_off_o | output | 1 | Block lock bits ignored |
| ctl_reset_o | output | 1 | Flash controller reset |
| user_area_o | output | 1 | 1 = user area mapped, 0 = boot area |
| flash_power_cut_o | output | 1 | Flash supply removed |
| flash_access_ok_o | output | 1 | Flash may be accessed |

## Verification
A wrong armed flag shows up one cycle after the next write of 1 to that register. The protected bit then reads back or drives its output differently from a bench model that tracks each register's last written bit. A gating fault between rewrite mode and its dependent bits shows up in the same cycle as a lock or reset output that is high while rewrite mode is low. Power faults show up combinationally on the cut and access outputs as soon as the sleep input or the power bit changes. Sweeps over every control byte and long mixed write sequences expose these states within one or two writes of when they arise.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int DATA_W    = 8;
  // bit positions in the control register
  localparam int C_READY   = 0;
  localparam int C_REWRITE = 1;
  localparam int C_LOCKOFF = 2;
  localparam int C_CRESET  = 3;
  localparam int C_AREA    = 5;
  // bit position in the power register
  localparam int P_PWROFF  = 3;
  // protected bit slots
  localparam int NPROT     = 3;
  localparam int S_REWRITE = 0;
  localparam int S_LOCKOFF = 1;
  localparam int S_PWROFF  = 2;

  typedef struct packed {
    logic wr_ctrl;
    logic wr_pwr;
    logic sel_ctrl;
    logic sel_pwr;
  } dec_t;
endpackage

// File: rtl/flash_ctl_decode.sv
module flash_ctl_decode
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h11
) (
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output dec_t              dec
);
  always_comb begin
    dec.sel_ctrl = (bus_addr == CTRL_ADDR);
    dec.sel_pwr  = (bus_addr == PWR_ADDR);
    dec.wr_ctrl  = bus_wr && dec.sel_ctrl;
    dec.wr_pwr   = bus_wr && dec.sel_pwr;
  end
endmodule

// File: rtl/flash_ctl_unlock_bit.sv
module flash_ctl_unlock_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_hit,
  input  logic wr_val,
  input  logic allow,
  output logic q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q     <= 1'b0;
      armed <= 1'b0;
    end else if (clr) begin
      q     <= 1'b0;
      armed <= 1'b0;
    end else if (wr_hit) begin
      if (!wr_val) begin
        q     <= 1'b0;
        armed <= 1'b1;
      end else begin
        if (armed && allow) q <= 1'b1;
        armed <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_ctl_power.sv
module flash_ctl_power (
  input  logic pwroff_bit,
  input  logic cpu_sleep,
  output logic power_cut,
  output logic access_ok
);
  always_comb begin
    power_cut = pwroff_bit | cpu_sleep;
    access_ok = ~power_cut;
  end
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import flash_ctl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              flash_ready_i,
  input  logic              boot_mode_i,
  input  logic              cpu_sleep_i,
  output logic              rewrite_mode_o,
  output logic              lock_off_o,
  output logic              ctl_reset_o,
  output logic              user_area_o,
  output logic              flash_power_cut_o,
  output logic              flash_access_ok_o
);
  dec_t dec;
  logic [NPROT-1:0] p_hit, p_val, p_allow, p_clr, p_q;
  logic creset_q, area_q;
  logic rw_drop;

  flash_ctl_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .PWR_ADDR(PWR_ADDR))
    u_dec (.bus_wr(bus_wr), .bus_addr(bus_addr), .dec(dec));

  // a write clearing rewrite mode, or rewrite mode off, drops dependent bits
  assign rw_drop = !p_q[S_REWRITE] || (dec.wr_ctrl && !bus_wdata[C_REWRITE]);

  always_comb begin
    p_hit[S_REWRITE]   = dec.wr_ctrl;
    p_val[S_REWRITE]   = bus_wdata[C_REWRITE];
    p_allow[S_REWRITE] = 1'b1;
    p_clr[S_REWRITE]   = 1'b0;
    p_hit[S_LOCKOFF]   = dec.wr_ctrl;
    p_val[S_LOCKOFF]   = bus_wdata[C_LOCKOFF];
    p_allow[S_LOCKOFF] = p_q[S_REWRITE];
    p_clr[S_LOCKOFF]   = rw_drop;
    p_hit[S_PWROFF]    = dec.wr_pwr;
    p_val[S_PWROFF]    = bus_wdata[P_PWROFF];
    p_allow[S_PWROFF]  = 1'b1;
    p_clr[S_PWROFF]    = 1'b0;
  end

  for (genvar g = 0; g < NPROT; g++) begin : g_prot
    flash_ctl_unlock_bit u_bit (
      .clk(clk), .rst_n(rst_n), .clr(p_clr[g]), .wr_hit(p_hit[g]),
      .wr_val(p_val[g]), .allow(p_allow[g]), .q(p_q[g]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      creset_q <= 1'b0;
      area_q   <= 1'b0;
    end else begin
      if (rw_drop)          creset_q <= 1'b0;
      else if (dec.wr_ctrl) creset_q <= bus_wdata[C_CRESET];
      if (dec.wr_ctrl)      area_q   <= bus_wdata[C_AREA];
    end
  end

  flash_ctl_power u_pwr (
    .pwroff_bit(p_q[S_PWROFF]), .cpu_sleep(cpu_sleep_i),
    .power_cut(flash_power_cut_o), .access_ok(flash_access_ok_o));

  always_comb begin
    bus_rdata = '0;
    if (dec.sel_ctrl) begin
      bus_rdata[C_READY]   = flash_ready_i;
      bus_rdata[C_REWRITE] = p_q[S_REWRITE];
      bus_rdata[C_LOCKOFF] = p_q[S_LOCKOFF];
      bus_rdata[C_CRESET]  = creset_q;
      bus_rdata[C_AREA]    = area_q;
    end else if (dec.sel_pwr) begin
      bus_rdata[P_PWROFF]  = p_q[S_PWROFF];
    end
  end

  assign rewrite_mode_o = p_q[S_REWRITE];
  assign lock_off_o     = p_q[S_LOCKOFF];
  assign ctl_reset_o    = creset_q;
  assign user_area_o    = !boot_mode_i || area_q;
endmodule

// File: rtl/flash_ctl_regs_chk.sv
module flash_ctl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h10,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 'h11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              flash_ready_i,
  input logic              boot_mode_i,
  input logic              cpu_sleep_i,
  input logic              rewrite_mode_o,
  input logic              lock_off_o,
  input logic              ctl_reset_o,
  input logic              user_area_o,
  input logic              flash_power_cut_o,
  input logic              flash_access_ok_o
);
  assert_ready_mirror_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_ADDR) |-> (bus_rdata[0] == flash_ready_i));

  assert_rewrite_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rewrite_mode_o) |-> $past(bus_wr && bus_addr == CTRL_ADDR && bus_wdata[1]));

  assert_lock_needs_rw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_off_o |-> rewrite_mode_o);

  assert_creset_needs_rw_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_reset_o |-> rewrite_mode_o);

  assert_area_nonboot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !boot_mode_i |-> user_area_o);

  assert_pwroff_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flash_access_ok_o) && !cpu_sleep_i) |->
      $past(bus_wr && bus_addr == PWR_ADDR && bus_wdata[3]));

  assert_sleep_cuts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_sleep_i |-> (flash_power_cut_o && !flash_access_ok_o));
endmodule

bind flash_ctl_regs flash_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .PWR_ADDR(PWR_ADDR)) u_chk (.*);

// File: tb/flash_ctl_regs_bench.sv
module flash_ctl_regs_bench;
  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_PWR   = 8'h11;
  localparam logic [7:0] A_OTHER = 8'h55;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [7:0] bus_addr = A_CTRL, bus_wdata = 0, bus_rdata;
  logic flash_ready_i = 1, boot_mode_i = 1, cpu_sleep_i = 0;
  logic rewrite_mode_o, lock_off_o, ctl_reset_o, user_area_o;
  logic flash_power_cut_o, flash_access_ok_o;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  bit m_rw, m_lk, m_rs, m_ua, m_po, a_rw, a_lk, a_po;

  always #5 clk = ~clk;

  flash_ctl_regs u_flash_ctl_regs (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    {m_rw, m_lk, m_rs, m_ua, m_po, a_rw, a_lk, a_po} = '0;
  endtask

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    bit rw_old;
    if (a == A_CTRL) begin
      rw_old = m_rw;
      if (!d[1]) begin m_rw = 0; a_rw = 1; end
      else begin if (a_rw) m_rw = 1; a_rw = 0; end
      if (!(rw_old && m_rw)) begin m_lk = 0; a_lk = 0; m_rs = 0; end
      else begin
        if (!d[2]) begin m_lk = 0; a_lk = 1; end
        else begin if (a_lk) m_lk = 1; a_lk = 0; end
        m_rs = d[3];
      end
      m_ua = d[5];
    end else if (a == A_PWR) begin
      if (!d[3]) begin m_po = 0; a_po = 1; end
      else begin if (a_po) m_po = 1; a_po = 0; end
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    model_write(a, d);
  endtask

  task automatic check_all(string req);
    logic [7:0] e0;
    e0 = {2'b00, m_ua, 1'b0, m_rs, m_lk, m_rw, flash_ready_i};
    bus_addr = A_CTRL; #1;
    chk(req, bus_rdata, e0);
    bus_addr = A_PWR; #1;
    chk(req, bus_rdata, {4'b0, m_po, 3'b0});
    bus_addr = A_OTHER; #1;
    chk({req, "/R9"}, bus_rdata, 8'h00);
    chk(req, {2'b0, rewrite_mode_o, lock_off_o, ctl_reset_o, user_area_o,
              flash_power_cut_o, flash_access_ok_o},
        {2'b0, m_rw, m_lk, m_rs, (!boot_mode_i) | m_ua,
         m_po | cpu_sleep_i, !(m_po | cpu_sleep_i)});
  endtask

  initial begin
    logic [15:0] lf;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1");
    flash_ready_i = 0; #1; check_all("R2");
    flash_ready_i = 1; #1; check_all("R2");

    // R3: lone write of 1 does nothing, 0 then 1 sets, 0 clears
    wr(A_CTRL, 8'h02); chk("R3", rewrite_mode_o, 0);
    wr(A_CTRL, 8'h00); wr(A_CTRL, 8'h02); chk("R3", rewrite_mode_o, 1);
    wr(A_CTRL, 8'h00); chk("R3", rewrite_mode_o, 0);
    // R10: intervening write to the power register keeps the arm
    wr(A_CTRL, 8'h00); wr(A_PWR, 8'h08); wr(A_CTRL, 8'h02);
    chk("R10", rewrite_mode_o, 1); chk("R10", flash_power_cut_o, 0);
    // R4: lock disable sequence while rewrite is on
    wr(A_CTRL, 8'h06); chk("R4", lock_off_o, 0);
    wr(A_CTRL, 8'h02); wr(A_CTRL, 8'h06); chk("R4", lock_off_o, 1);
    // R5: controller reset while rewrite is on
    wr(A_CTRL, 8'h0E); chk("R5", ctl_reset_o, 1);
    wr(A_CTRL, 8'h04); chk("R4", lock_off_o, 0); chk("R5", ctl_reset_o, 0);
    wr(A_CTRL, 8'h08); chk("R5", ctl_reset_o, 0);
    // R9: other address writes have no effect
    wr(A_OTHER, 8'hFF); check_all("R9");
    // R6: area select with and without boot mode
    wr(A_CTRL, 8'h20); boot_mode_i = 1; #1; chk("R6", user_area_o, 1);
    wr(A_CTRL, 8'h00); chk("R6", user_area_o, 0);
    boot_mode_i = 0; #1; chk("R6", user_area_o, 1);
    boot_mode_i = 1;
    // R7/R8: power bit and sleep
    wr(A_PWR, 8'h00); wr(A_PWR, 8'h08); chk("R7", flash_power_cut_o, 1);
    chk("R8", flash_access_ok_o, 0);
    wr(A_PWR, 8'h00); chk("R7", flash_power_cut_o, 0);
    cpu_sleep_i = 1; #1; chk("R8", flash_access_ok_o, 0);
    cpu_sleep_i = 0; #1; chk("R8", flash_access_ok_o, 1);
    check_all("R1-state");

    // exhaustive sweeps over control bytes in two orders
    for (int i = 0; i < 256; i++) begin
      wr(A_CTRL, i[7:0]); check_all("R3/R4/R5/R6");
    end
    for (int i = 255; i >= 0; i--) begin
      wr(A_CTRL, i[7:0] ^ (i[7:0] >> 1)); check_all("R3/R4/R5/R6");
    end
    for (int i = 0; i < 16; i++) begin
      wr(A_PWR, {i[3:0], i[3:0]}); check_all("R7");
    end

    // mixed traffic from an LFSR
    lf = 16'hACE1;
    for (int i = 0; i < 800; i++) begin
      logic [7:0] a;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a = (lf[9:8] == 2'd0 || lf[9:8] == 2'd1) ? A_CTRL :
          (lf[9:8] == 2'd2) ? A_PWR : A_OTHER;
      wr(a, lf[7:0] & {2'b11, ~lf[11], 5'h1F});
      flash_ready_i = lf[12]; boot_mode_i = lf[13]; cpu_sleep_i = lf[14] & lf[15];
      #1;
      check_all("R8/R10");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule